// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox between a host processor and an embedded management controller. The host posts up to four 32-bit words of argument data into an outbound buffer, then writes a command word. That write latches the word for the controller, pulses a doorbell toward it and marks the mailbox busy. The controller runs the command and can leave up to four result words in an inbound buffer. It then strobes completion, carrying a fault flag and an 8-bit fault code.

The host learns of completion in one of two ways. It can poll the status word until the busy bit drops and then inspect the fault bit. Or it can set the notify bit in the command word, and it then receives a single-cycle interrupt pulse when the controller completes. The inbound buffer can be read by the host as whole words or as single bytes.

Top module: `host_ctrl_mailbox`

## Requirements
- R1: After reset, the status word reads 0 except bits 15:8, which hold the INIT_ID parameter. The doorbell, host interrupt and read data are all 0.
- R2: A host write to offset 0x00 copies the data to `ctl_cmd` at the next clock. It pulses `ctl_doorbell` high for exactly the following cycle and sets busy at the same edge.
- R3: The status word at offset 0x04 has this layout:
  - bit 0: busy
  - bit 1: fault
  - bits 3:2: zero
  - bits 7:4: bits 15:12 of the last command word
  - bits 15:8: INIT_ID
  - bits 23:16: fault code
  - bits 31:24: zero
- R4: A completion strobe while busy clears busy and latches `ctl_err` and `ctl_ecode` into the fault bit and fault code, all at the same edge.
- R5: `host_irq` is a one-cycle pulse on the cycle after an accepted completion, and only when bit 8 of the command being completed was 1.
- R6: A new command write clears the fault bit and the fault code.
- R7: A completion strobe while not busy is ignored: the status does not change and no interrupt fires.
- R8: A command write in the same cycle as a completion strobe wins. Busy stays set, the fault fields are cleared and no interrupt fires.
- R9: A host write to offset 0x80+4i stores the word in outbound slot i (i from 0 to 3). The slot is read combinationally on `ctl_wb_word` while `ctl_wb_idx` = i.
- R10: A controller write stores `ctl_rb_wdata` in inbound slot `ctl_rb_idx`.
  - A host word read (`hst_byte`=0) at 0x90+4i returns slot i.
  - A byte read (`hst_byte`=1) at 0x90+n returns byte n mod 4 of slot n/4 in bits 7:0, with the upper bits 0.
- R11: Read data is registered: it updates at the edge that samples `hst_rd` and holds otherwise.
  - Reads of the command register, the outbound buffer and unmapped offsets return 0.
  - Host writes to the status register, the inbound buffer and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_addr | input | ADDR_W (8) | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_byte | input | 1 | Read width select: 1 for a byte read, 0 for a word read |
| hst_rdata | output | 32 | Registered host read data |
| host_irq | output | 1 | Completion interrupt pulse to the host |
| ctl_cmd | output | 32 | Latched command word |
| ctl_doorbell | output | 1 | Command-arrival pulse to the controller |
| ctl_wb_idx | input | log2(BUF_WORDS) (2) | Outbound slot select |
| ctl_wb_word | output | 32 | Selected outbound slot |
| ctl_rb_we | input | 1 | Inbound slot write enable |
| ctl_rb_idx | input | log2(BUF_WORDS) (2) | Inbound slot select |
| ctl_rb_wdata | input | 32 | Inbound slot write data |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Fault flag, sampled with `ctl_done` |
| ctl_ecode | input | 8 | Fault code, sampled with `ctl_done` |

## Verification
A busy flag that is stuck, or cleared at the wrong time, shows in the very next status read. It also shows as a missing or extra `host_irq` pulse one cycle after the completion strobe.

A wrong fault latch or a wrong arbitration between a command write and a completion in the same cycle corrupts bits 1 and 23:16 of status from the next edge on. A wrong buffer index or byte lane shows at once on `ctl_wb_word`, or one cycle after the read strobe on `hst_rdata`.

A reference model advances with every clock and is compared on every cycle. Misbehaviour is therefore caught within one cycle of the edge that causes it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int WORD_W = 32;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic [7:0] rsv_hi;
      logic [7:0] xfer_len;
      logic [3:0] cmd_id;
      logic [2:0] rsv_lo;
      logic       notify;
      logic [7:0] opcode;
   } cmd_word_t;

   typedef struct packed {
      logic [7:0] rsv_hi;
      logic [7:0] fault_code;
      logic [7:0] origin;
      logic [3:0] cmd_id;
      logic [1:0] rsv_lo;
      logic       fault;
      logic       busy;
   } stat_word_t;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_CMD,
      RG_STAT,
      RG_WBUF,
      RG_RBUF
   } region_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
   import mbx_pkg::*;
#(
   parameter int              ADDR_W    = 8,
   parameter int              IDX_W     = 2,
   parameter int              BUF_BYTES = 16,
   parameter logic [ADDR_W-1:0] CMD_OFS  = 'h00,
   parameter logic [ADDR_W-1:0] STAT_OFS = 'h04,
   parameter logic [ADDR_W-1:0] WBUF_BASE = 'h80,
   parameter logic [ADDR_W-1:0] RBUF_BASE = 'h90
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [IDX_W-1:0]  word_idx,
   output logic [1:0]        lane
);
   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(BUF_BYTES);

   logic [ADDR_W-1:0] wofs;
   logic [ADDR_W-1:0] rofs;

   assign wofs = addr - WBUF_BASE;
   assign rofs = addr - RBUF_BASE;
   assign lane = addr[1:0];

   always_comb begin
      region   = RG_NONE;
      word_idx = wofs[IDX_W+1:2];
      if (addr == CMD_OFS) begin
         region = RG_CMD;
      end else if (addr == STAT_OFS) begin
         region = RG_STAT;
      end else if (wofs < SPAN) begin
         region = RG_WBUF;
      end else if (rofs < SPAN) begin
         region   = RG_RBUF;
         word_idx = rofs[IDX_W+1:2];
      end
   end
endmodule

// File: rtl/mbx_buf.sv
module mbx_buf #(
   parameter int WORDS  = 4,
   parameter int IDX_W  = 2,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);
   localparam int FLAT_W = WORDS * DATA_W;

   logic [FLAT_W-1:0] flat;

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (we && (widx == IDX_W'(gi))) begin
            slot_q <= wdata;
         end
      end
      assign flat[gi*DATA_W +: DATA_W] = slot_q;
   end

   assign rdata = flat[int'(ridx)*DATA_W +: DATA_W];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
   import mbx_pkg::*;
#(
   parameter logic [7:0] INIT_ID = 8'hA7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_i,
   input  logic [WORD_W-1:0] cmd_word_i,
   input  logic              done_i,
   input  logic              fault_i,
   input  logic [7:0]        fault_code_i,
   output logic [WORD_W-1:0] cmd_o,
   output logic              doorbell_o,
   output logic              irq_o,
   output logic [WORD_W-1:0] status_o
);
   cmd_word_t  cmd_q;
   stat_word_t st;
   logic       busy_q;
   logic       fault_q;
   logic [7:0] code_q;
   logic       bell_q;
   logic       irq_q;
   logic       accept_done;

   assign accept_done = done_i && busy_q && !cmd_wr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         busy_q  <= 1'b0;
         fault_q <= 1'b0;
         code_q  <= '0;
         bell_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         bell_q <= cmd_wr_i;
         irq_q  <= 1'b0;
         if (cmd_wr_i) begin
            cmd_q   <= cmd_word_t'(cmd_word_i);
            busy_q  <= 1'b1;
            fault_q <= 1'b0;
            code_q  <= '0;
         end else if (accept_done) begin
            busy_q  <= 1'b0;
            fault_q <= fault_i;
            code_q  <= fault_code_i;
            irq_q   <= cmd_q.notify;
         end
      end
   end

   always_comb begin
      st            = '0;
      st.busy       = busy_q;
      st.fault      = fault_q;
      st.cmd_id     = cmd_q.cmd_id;
      st.origin     = INIT_ID;
      st.fault_code = code_q;
   end

   assign cmd_o      = cmd_q;
   assign doorbell_o = bell_q;
   assign irq_o      = irq_q;
   assign status_o   = st;

   assert_busy_on_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr_i |=> (status_o[0] && doorbell_o));

   assert_doorbell_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (doorbell_o && !cmd_wr_i) |=> !doorbell_o);

   assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && status_o[0] && !cmd_wr_i) |=>
         (!status_o[0] && status_o[1] == $past(fault_i) && status_o[23:16] == $past(fault_code_i)));

   assert_irq_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (!status_o[0] && !doorbell_o));

   assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   assert_new_cmd_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr_i |=> (!status_o[1] && status_o[23:16] == 8'h00));

   assert_idle_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !status_o[0] && !cmd_wr_i) |=> ($stable(status_o) && !irq_o));

   assert_cmd_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && done_i) |=> (status_o[0] && !irq_o));
endmodule

// File: rtl/host_ctrl_mailbox.sv
module host_ctrl_mailbox
   import mbx_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                BUF_WORDS = 4,
   parameter logic [ADDR_W-1:0] WBUF_BASE = 'h80,
   parameter logic [ADDR_W-1:0] RBUF_BASE = 'h90,
   parameter logic [7:0]        INIT_ID   = 8'hA7,
   localparam int               IDX_W     = $clog2(BUF_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] hst_addr,
   input  logic [31:0]       hst_wdata,
   input  logic              hst_wr,
   input  logic              hst_rd,
   input  logic              hst_byte,
   output logic [31:0]       hst_rdata,
   output logic              host_irq,
   output logic [31:0]       ctl_cmd,
   output logic              ctl_doorbell,
   input  logic [IDX_W-1:0]  ctl_wb_idx,
   output logic [31:0]       ctl_wb_word,
   input  logic              ctl_rb_we,
   input  logic [IDX_W-1:0]  ctl_rb_idx,
   input  logic [31:0]       ctl_rb_wdata,
   input  logic              ctl_done,
   input  logic              ctl_err,
   input  logic [7:0]        ctl_ecode
);
   localparam int BUF_BYTES = BUF_WORDS * (WORD_W / BYTE_W);
   localparam logic [ADDR_W-1:0] CMD_OFS  = 'h00;
   localparam logic [ADDR_W-1:0] STAT_OFS = 'h04;

   if (BUF_WORDS < 2 || (BUF_WORDS & (BUF_WORDS - 1)) != 0) begin : g_bad_words
      $error("BUF_WORDS must be a power of two of at least 2");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (WBUF_BASE[1:0] != 2'b00 || RBUF_BASE[1:0] != 2'b00) begin : g_bad_align
      $error("buffer bases must be word aligned");
   end
   if (int'(WBUF_BASE) < 8 || int'(RBUF_BASE) < 8) begin : g_bad_low
      $error("buffers overlap command or status offsets");
   end
   if (!(int'(RBUF_BASE) >= int'(WBUF_BASE) + BUF_BYTES ||
         int'(WBUF_BASE) >= int'(RBUF_BASE) + BUF_BYTES)) begin : g_bad_overlap
      $error("buffer windows overlap");
   end

   region_e           region;
   logic [IDX_W-1:0]  word_idx;
   logic [1:0]        lane;
   logic              cmd_wr;
   logic [WORD_W-1:0] status;
   logic [WORD_W-1:0] rb_word;
   logic [WORD_W-1:0] rdata_q;
   logic [WORD_W-1:0] rb_lane_word;

   mbx_decode #(
      .ADDR_W    (ADDR_W),
      .IDX_W     (IDX_W),
      .BUF_BYTES (BUF_BYTES),
      .CMD_OFS   (CMD_OFS),
      .STAT_OFS  (STAT_OFS),
      .WBUF_BASE (WBUF_BASE),
      .RBUF_BASE (RBUF_BASE)
   ) u_decode (
      .addr     (hst_addr),
      .region   (region),
      .word_idx (word_idx),
      .lane     (lane)
   );

   assign cmd_wr = hst_wr && (region == RG_CMD);

   mbx_ctrl #(
      .INIT_ID (INIT_ID)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_wr_i     (cmd_wr),
      .cmd_word_i   (hst_wdata),
      .done_i       (ctl_done),
      .fault_i      (ctl_err),
      .fault_code_i (ctl_ecode),
      .cmd_o        (ctl_cmd),
      .doorbell_o   (ctl_doorbell),
      .irq_o        (host_irq),
      .status_o     (status)
   );

   mbx_buf #(
      .WORDS  (BUF_WORDS),
      .IDX_W  (IDX_W),
      .DATA_W (WORD_W)
   ) u_outbound (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (hst_wr && (region == RG_WBUF)),
      .widx  (word_idx),
      .wdata (hst_wdata),
      .ridx  (ctl_wb_idx),
      .rdata (ctl_wb_word)
   );

   mbx_buf #(
      .WORDS  (BUF_WORDS),
      .IDX_W  (IDX_W),
      .DATA_W (WORD_W)
   ) u_inbound (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ctl_rb_we),
      .widx  (ctl_rb_idx),
      .wdata (ctl_rb_wdata),
      .ridx  (word_idx),
      .rdata (rb_word)
   );

   always_comb begin
      rb_lane_word = rb_word;
      if (hst_byte) begin
         rb_lane_word = {{(WORD_W-BYTE_W){1'b0}}, rb_word[{lane, 3'b000} +: BYTE_W]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (hst_rd) begin
         unique case (region)
            RG_STAT: rdata_q <= status;
            RG_RBUF: rdata_q <= rb_lane_word;
            default: rdata_q <= '0;
         endcase
      end
   end

   assign hst_rdata = rdata_q;

   assert_hidden_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && (region == RG_NONE || region == RG_CMD || region == RG_WBUF)) |=> (hst_rdata == '0));

   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !hst_rd |=> $stable(hst_rdata));

   assert_byte_read_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_rd && hst_byte && region == RG_RBUF) |=> (hst_rdata[31:8] == 24'h0));
endmodule

// File: tb/host_ctrl_mailbox_bench.sv
`timescale 1ns/1ps
module host_ctrl_mailbox_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  hst_addr;
   logic [31:0] hst_wdata;
   logic        hst_wr, hst_rd, hst_byte;
   logic [31:0] hst_rdata;
   logic        host_irq;
   logic [31:0] ctl_cmd;
   logic        ctl_doorbell;
   logic [1:0]  ctl_wb_idx;
   logic [31:0] ctl_wb_word;
   logic        ctl_rb_we;
   logic [1:0]  ctl_rb_idx;
   logic [31:0] ctl_rb_wdata;
   logic        ctl_done, ctl_err;
   logic [7:0]  ctl_ecode;

   always #4 clk = ~clk;

   host_ctrl_mailbox u_host_ctrl_mailbox (
      .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
      .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_byte(hst_byte), .hst_rdata(hst_rdata),
      .host_irq(host_irq), .ctl_cmd(ctl_cmd), .ctl_doorbell(ctl_doorbell),
      .ctl_wb_idx(ctl_wb_idx), .ctl_wb_word(ctl_wb_word), .ctl_rb_we(ctl_rb_we),
      .ctl_rb_idx(ctl_rb_idx), .ctl_rb_wdata(ctl_rb_wdata), .ctl_done(ctl_done),
      .ctl_err(ctl_err), .ctl_ecode(ctl_ecode)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 0;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [31:0] m_cmd, m_rdata;
   logic        m_busy, m_err, m_db, m_irq;
   logic [7:0]  m_code;
   logic [31:0] m_wb [4];
   logic [31:0] m_rb [4];
   string       m_rtag = "R11";

   function automatic logic [31:0] m_status();
      return {8'h00, m_code, 8'hA7, m_cmd[15:12], 2'b00, m_err, m_busy};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmd = 0; m_rdata = 0; m_busy = 0; m_err = 0; m_db = 0; m_irq = 0; m_code = 0;
         for (int i = 0; i < 4; i++) begin m_wb[i] = 0; m_rb[i] = 0; end
      end else begin
         if (hst_rd) begin
            if (hst_addr == 8'h04) begin
               m_rdata = m_status(); m_rtag = "R3";
            end else if (hst_addr >= 8'h90 && hst_addr <= 8'h9F) begin
               m_rtag = "R10";
               if (hst_byte) m_rdata = {24'h0, m_rb[(hst_addr - 8'h90) / 4][hst_addr[1:0]*8 +: 8]};
               else m_rdata = m_rb[(hst_addr - 8'h90) / 4];
            end else begin
               m_rdata = 0; m_rtag = "R11";
            end
         end
         m_db  = hst_wr && hst_addr == 8'h00;
         m_irq = 0;
         if (m_db) begin
            m_cmd = hst_wdata; m_busy = 1; m_err = 0; m_code = 0;
         end else if (ctl_done && m_busy) begin
            m_busy = 0; m_err = ctl_err; m_code = ctl_ecode; m_irq = m_cmd[8];
         end
         if (hst_wr && hst_addr >= 8'h80 && hst_addr <= 8'h8F) m_wb[(hst_addr - 8'h80) / 4] = hst_wdata;
         if (ctl_rb_we) m_rb[ctl_rb_idx] = ctl_rb_wdata;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk("R2", "ctl_cmd", ctl_cmd, m_cmd);
         chk("R2", "ctl_doorbell", {31'h0, ctl_doorbell}, {31'h0, m_db});
         chk("R5", "host_irq", {31'h0, host_irq}, {31'h0, m_irq});
         chk(m_rtag, "hst_rdata", hst_rdata, m_rdata);
         chk("R9", "ctl_wb_word", ctl_wb_word, m_wb[ctl_wb_idx]);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic go_idle();
      hst_wr = 0; hst_rd = 0; hst_byte = 0; hst_addr = 0; hst_wdata = 0;
      ctl_rb_we = 0; ctl_rb_idx = 0; ctl_rb_wdata = 0; ctl_done = 0; ctl_err = 0; ctl_ecode = 0;
   endtask

   task automatic tick();
      @(posedge clk); #2;
      go_idle();
   endtask

   task automatic host_write(input logic [7:0] a, input logic [31:0] d);
      hst_wr = 1; hst_addr = a; hst_wdata = d;
      tick();
   endtask

   task automatic host_read(input logic [7:0] a, input logic byt, output logic [31:0] v);
      hst_rd = 1; hst_addr = a; hst_byte = byt;
      tick();
      v = hst_rdata;
   endtask

   task automatic ctl_complete(input logic e, input logic [7:0] c);
      ctl_done = 1; ctl_err = e; ctl_ecode = c;
      tick();
   endtask

   task automatic ctl_fill(input logic [1:0] i, input logic [31:0] d);
      ctl_rb_we = 1; ctl_rb_idx = i; ctl_rb_wdata = d;
      tick();
   endtask

   task automatic finish_run();
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #200000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      go_idle();
      ctl_wb_idx = 0;
      rst_n = 0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      tick();

      // R1: reset state
      chk("R1", "doorbell after reset", {31'h0, ctl_doorbell}, 32'h0);
      chk("R1", "irq after reset", {31'h0, host_irq}, 32'h0);
      chk("R1", "rdata after reset", hst_rdata, 32'h0);
      host_read(8'h04, 0, v);
      chk("R1", "status after reset", v, 32'h0000A700);

      // R9: outbound buffer
      for (int i = 0; i < 4; i++) host_write(8'h80 + 8'(4*i), 32'h1111_0000 + 32'(i * 32'h0101));
      for (int i = 0; i < 4; i++) begin
         ctl_wb_idx = 2'(i); #1;
         chk("R9", "outbound slot", ctl_wb_word, 32'h1111_0000 + 32'(i * 32'h0101));
      end
      ctl_wb_idx = 0;

      // R2/R3: command with notify bit
      host_write(8'h00, 32'h0004_3123);
      chk("R2", "doorbell pulse", {31'h0, ctl_doorbell}, 32'h1);
      chk("R2", "latched command", ctl_cmd, 32'h0004_3123);
      host_read(8'h04, 0, v);
      chk("R2", "doorbell single cycle", {31'h0, ctl_doorbell}, 32'h0);
      chk("R3", "status busy with id", v, 32'h0000A731);

      // R4/R5: faulted completion with interrupt
      ctl_complete(1'b1, 8'h5C);
      chk("R5", "irq pulse on notify", {31'h0, host_irq}, 32'h1);
      host_read(8'h04, 0, v);
      chk("R5", "irq single cycle", {31'h0, host_irq}, 32'h0);
      chk("R4", "status after fault completion", v, 32'h005CA732);

      // R7: completion while idle
      ctl_complete(1'b0, 8'h11);
      chk("R7", "no irq when idle", {31'h0, host_irq}, 32'h0);
      host_read(8'h04, 0, v);
      chk("R7", "status unchanged", v, 32'h005CA732);

      // R6: new command clears fault
      host_write(8'h00, 32'h0000_7044);
      host_read(8'h04, 0, v);
      chk("R6", "fault cleared by command", v, 32'h0000A771);
      ctl_complete(1'b0, 8'h00);
      chk("R5", "no irq without notify", {31'h0, host_irq}, 32'h0);
      host_read(8'h04, 0, v);
      chk("R4", "status after clean completion", v, 32'h0000A770);

      // R8: command and completion together
      hst_wr = 1; hst_addr = 8'h00; hst_wdata = 32'h0000_9145;
      ctl_done = 1; ctl_err = 1; ctl_ecode = 8'hEE;
      tick();
      chk("R8", "no irq on collision", {31'h0, host_irq}, 32'h0);
      host_read(8'h04, 0, v);
      chk("R8", "command wins", v, 32'h0000A791);
      ctl_complete(1'b1, 8'h07);
      chk("R5", "irq after second command", {31'h0, host_irq}, 32'h1);
      host_read(8'h04, 0, v);
      chk("R4", "status after second completion", v, 32'h0007A792);

      // R10: inbound buffer
      ctl_fill(2'd2, 32'hDEAD_BEEF);
      ctl_fill(2'd0, 32'h0102_0304);
      host_read(8'h98, 0, v);
      chk("R10", "word read slot 2", v, 32'hDEAD_BEEF);
      host_read(8'h9B, 1, v);
      chk("R10", "byte read lane 3", v, 32'h0000_00DE);
      host_read(8'h99, 1, v);
      chk("R10", "byte read lane 1", v, 32'h0000_00BE);
      host_read(8'h90, 1, v);
      chk("R10", "byte read lane 0", v, 32'h0000_0004);

      // R11: hidden and unmapped offsets
      host_write(8'h04, 32'hFFFF_FFFF);
      host_write(8'h94, 32'h1234_5678);
      host_write(8'h40, 32'hCAFE_F00D);
      host_read(8'h04, 0, v);
      chk("R11", "status write ignored", v, 32'h0007A792);
      host_read(8'h94, 0, v);
      chk("R11", "inbound write ignored", v, 32'h0);
      host_read(8'h00, 0, v);
      chk("R11", "command reads zero", v, 32'h0);
      host_read(8'h80, 0, v);
      chk("R11", "outbound reads zero", v, 32'h0);
      host_read(8'h40, 0, v);
      chk("R11", "unmapped reads zero", v, 32'h0);
      tick();
      chk("R11", "rdata holds without read", hst_rdata, 32'h0);

      // mixed traffic compared against the model every cycle
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r;
         r = $urandom;
         case (r[6:4])
            3'd0: hst_addr = 8'h00;
            3'd1: hst_addr = 8'h04;
            3'd2: hst_addr = 8'h80 | {4'h0, r[9:8], 2'b00};
            3'd3: hst_addr = 8'h90 | {4'h0, r[11:8]};
            3'd4: hst_addr = 8'h40;
            3'd5: hst_addr = 8'hA0;
            3'd6: hst_addr = 8'h8C;
            default: hst_addr = 8'h9C;
         endcase
         hst_rd       = r[12];
         hst_byte     = r[13];
         hst_wr       = r[14] & r[15];
         hst_wdata    = $urandom;
         ctl_done     = r[16] & r[17];
         ctl_err      = r[18];
         ctl_ecode    = r[26:19];
         ctl_rb_we    = r[27];
         ctl_rb_idx   = r[29:28];
         ctl_rb_wdata = $urandom;
         ctl_wb_idx   = r[31:30];
         @(posedge clk); #2;
      end
      go_idle();
      tick();
      finish_run();
   end
endmodule